// File: doc/BRIEF.md
# Wide-Word Memory Self-Test Engine

This block is a built-in self-test controller for an embedded memory array. It runs once by itself when reset is released. It can run again whenever it is idle and `start` is pulsed. For each selected data pattern it writes the whole array in a chosen address order, then reads it back in the same order. Every returned word is checked by one comparator per bit line, so the full word width is checked in a single access.

Any word that differs from what was written becomes a failure record. The record holds the word address and a mask of the bit lines that mismatched. Records leave on a valid/ready stream that feeds a repair allocator. When every record has been accepted downstream, the engine gives a one-cycle `done` pulse together with an overall pass flag and the number of failing words. Control then passes to the repair step.

Address ordering follows a `{row, col}` layout, with the column index in the low `COL_W` bits.

Failure stream rules:
- A record stays on `fail_addr`/`fail_mask` with `fail_valid` high until it is accepted in a cycle where `fail_ready` is high.
- Back-pressure never drops a record. A small record queue applies credits, and the read sequencer holds off new reads until every read still in flight is sure to find room in that queue.

Top module: `mem_selftest`

## Requirements
- R1: After reset is released, the engine starts a run by itself on the first clock edge, using the configuration inputs present at that edge. `busy` is high from then until the `done` cycle.
- R2: The configuration (`cfg_pat_en`, `cfg_desc`, `cfg_row_fast`) is captured when a run launches. Changes to it during a run, and `start` pulses during a run, have no effect on that run.
- R3: Pattern encodings:
  - index 0 is all zeros;
  - index 1 is all ones;
  - index 2 is a checkerboard: 0xAAAAAAAA where row bit 0 XOR col bit 0 is 0, otherwise 0x55555555;
  - index 3 is the inverse of index 2.
- R4: Enabled patterns run in ascending index order, back to back. Each pattern makes one full write pass followed by one full read pass in the same address order.
- R5: Address order is set by two bits:
  - `cfg_desc`=0 visits sequence index i = 0..N-1; `cfg_desc`=1 visits N-1..0.
  - With `cfg_row_fast`=0 the address is i itself, so the column changes fastest.
  - With `cfg_row_fast`=1 the row is the low `ROW_W` bits of i and the column is the high bits of i.
- R6: Each returned word is compared bit by bit against the written pattern. A record is produced only when at least one bit differs. `fail_mask` bit b is 1 exactly when data bit b differs. Records appear in read order.
- R7: Read data is taken `RD_LAT` cycles after the request. A failing record reaches an empty output queue so that `fail_valid` is first sampled high `RD_LAT`+1 rising edges after the edge that accepted the read.
- R8: While `fail_valid` is high and `fail_ready` is low, the record holds stable. No record is lost or duplicated under any back-pressure.
- R9: When `fail_ready` stays high, a read pass issues one read every cycle for N consecutive cycles, and a write pass writes one word every cycle.
- R10: `done` is a single-cycle pulse that comes only after all records have been accepted. `fail_total` gives the number of failing words and `pass` is 1 exactly when that number is 0; both hold until the next run ends.
- R11: With no pattern enabled, a run makes no memory access and ends with `done`, `pass`=1 and `fail_total`=0.
- R12: `mem_we` and `mem_re` are never high together, and neither is high while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a run when idle |
| cfg_pat_en | input | 4 | Enable mask for patterns 0..3 |
| cfg_desc | input | 1 | Descending address order |
| cfg_row_fast | input | 1 | Row index changes fastest |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run found no failing word |
| fail_total | output | CNT_W | Failing words in last run |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | ROW_W+COL_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Read data, valid RD_LAT cycles after request |
| fail_valid | output | 1 | Failure record available |
| fail_ready | input | 1 | Downstream accepts record |
| fail_addr | output | ROW_W+COL_W | Failing word address |
| fail_mask | output | DATA_W | Mismatching bit lines |

## Verification
Write-pass and read-pass addresses are logged at the clock edge where the strobe is sampled, and compared with the order the bench computes from R5.

The first failure record must be sampled valid exactly `RD_LAT`+1 edges after its read request was accepted. The bench stamps both events with one edge counter and checks the difference.

`done`, `pass` and `fail_total` change together at one edge, so the bench reads them on the falling edge inside the `done` cycle. Inputs are driven on falling edges, and the design is sampled either on falling edges or, in the monitors, at rising edges on values that have been stable since the preceding falling edge.

// File: rtl/mst_pkg.sv
package mst_pkg;
  localparam int NPAT = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WRITE,
    S_READ,
    S_DRAIN,
    S_FLUSH,
    S_DONE
  } mst_state_e;
endpackage

// File: rtl/mst_addr_seq.sv
module mst_addr_seq #(
  parameter int ROW_W = 3,
  parameter int COL_W = 3,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic              desc,
  input  logic              row_fast,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [ADDR_W-1:0] idx_q;
  logic [ADDR_W-1:0] lin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (clr)   idx_q <= '0;
    else if (step)  idx_q <= idx_q + 1'b1;
  end

  // descending order is the ones complement of the index (N is a power of two)
  assign lin  = desc ? ~idx_q : idx_q;
  assign addr = row_fast ? {lin[ROW_W-1:0], lin[ADDR_W-1:ROW_W]} : lin;
  assign last = &idx_q;

  p_pass_wraps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !clr) |=> (idx_q == '0));
endmodule

// File: rtl/mst_bitcmp.sv
module mst_bitcmp #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_v,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [DATA_W-1:0] iss_exp,
  input  logic [DATA_W-1:0] rdata,
  output logic              res_v,
  output logic [ADDR_W-1:0] res_addr,
  output logic [DATA_W-1:0] res_mask,
  output logic              res_fail
);
  logic              v_q [LAT];
  logic [ADDR_W-1:0] a_q [LAT];
  logic [DATA_W-1:0] e_q [LAT];

  // delay line matched to the memory read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) begin
        v_q[s] <= 1'b0;
        a_q[s] <= '0;
        e_q[s] <= '0;
      end
    end else begin
      v_q[0] <= iss_v;
      a_q[0] <= iss_addr;
      e_q[0] <= iss_exp;
      for (int s = 1; s < LAT; s++) begin
        v_q[s] <= v_q[s-1];
        a_q[s] <= a_q[s-1];
        e_q[s] <= e_q[s-1];
      end
    end
  end

  assign res_v    = v_q[LAT-1];
  assign res_addr = a_q[LAT-1];

  // one comparator per bit line
  for (genvar b = 0; b < DATA_W; b++) begin : g_bitline
    assign res_mask[b] = v_q[LAT-1] & (e_q[LAT-1][b] ^ rdata[b]);
  end

  assign res_fail = |res_mask;

  p_mask_only_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_v |-> (res_mask == '0));
endmodule

// File: rtl/mst_fail_fifo.sv
module mst_fail_fifo #(
  parameter int W     = 38,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (cnt_q != '0);
  assign pop       = out_valid && out_ready;
  assign dout      = store_q[rp_q];
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (push) store_q[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CW'(DEPTH)));

  p_hold_record_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dout)));
endmodule

// File: rtl/mem_selftest.sv
module mem_selftest
  import mst_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 32,
  parameter int RD_LAT = 2,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int CNT_W  = $clog2(NPAT * (1 << ADDR_W) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NPAT-1:0]   cfg_pat_en,
  input  logic              cfg_desc,
  input  logic              cfg_row_fast,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [CNT_W-1:0]  fail_total,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fail_valid,
  input  logic              fail_ready,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_mask
);
  localparam int DEPTH = RD_LAT + 2;
  localparam int QCW   = $clog2(DEPTH + 1);
  localparam int IFW   = $clog2(RD_LAT + 2);
  localparam int RW    = ADDR_W + DATA_W;

  mst_state_e        state_q;
  logic              boot_q;
  logic [NPAT-1:0]   pat_en_q;
  logic              desc_q, rowf_q;
  logic [1:0]        pat_q;
  logic [IFW-1:0]    infl_q;
  logic [CNT_W-1:0]  fcnt_q;
  logic              pass_q;
  logic [CNT_W-1:0]  total_q;

  logic              clr, step, last, can_issue;
  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] pat_word;
  logic              res_v, res_fail;
  logic [ADDR_W-1:0] res_addr;
  logic [DATA_W-1:0] res_mask;
  logic [QCW-1:0]    q_cnt;
  logic [RW-1:0]     q_dout;
  logic [2:0]        first_sel, next_sel;

  // lowest enabled pattern index strictly above 'from' (from = -1 for first)
  function automatic logic [2:0] pick_pat(input logic [NPAT-1:0] m, input int from);
    logic [2:0] r;
    r = '0;
    for (int k = NPAT - 1; k >= 0; k--) begin
      if (m[k] && k > from) r = {1'b1, 2'(k)};
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] gen_pattern(input logic [1:0] p,
                                                    input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] chk;
    chk = (a[0] ^ a[COL_W]) ? {(DATA_W/2){2'b01}} : {(DATA_W/2){2'b10}};
    case (p)
      2'd0:    return '0;
      2'd1:    return '1;
      2'd2:    return chk;
      default: return ~chk;
    endcase
  endfunction

  assign first_sel = pick_pat(cfg_pat_en, -1);
  assign next_sel  = pick_pat(pat_en_q, int'(pat_q));

  assign can_issue = (int'(q_cnt) + int'(infl_q)) < DEPTH;
  assign mem_we    = (state_q == S_WRITE);
  assign mem_re    = (state_q == S_READ) && can_issue;
  assign step      = mem_we || mem_re;
  assign clr       = (state_q == S_IDLE);
  assign pat_word  = gen_pattern(pat_q, seq_addr);
  assign mem_addr  = seq_addr;
  assign mem_wdata = pat_word;

  assign busy       = (state_q != S_IDLE);
  assign done       = (state_q == S_DONE);
  assign pass       = pass_q;
  assign fail_total = total_q;
  assign fail_addr  = q_dout[RW-1:DATA_W];
  assign fail_mask  = q_dout[DATA_W-1:0];

  mst_addr_seq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
    .desc(desc_q), .row_fast(rowf_q), .addr(seq_addr), .last(last)
  );

  mst_bitcmp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LAT(RD_LAT)) u_cmp (
    .clk(clk), .rst_n(rst_n), .iss_v(mem_re), .iss_addr(seq_addr),
    .iss_exp(pat_word), .rdata(mem_rdata), .res_v(res_v),
    .res_addr(res_addr), .res_mask(res_mask), .res_fail(res_fail)
  );

  mst_fail_fifo #(.W(RW), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(res_v && res_fail),
    .din({res_addr, res_mask}), .out_valid(fail_valid),
    .out_ready(fail_ready), .dout(q_dout), .count(q_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      infl_q <= '0;
      fcnt_q <= '0;
    end else begin
      infl_q <= infl_q + IFW'(mem_re) - IFW'(res_v);
      if (state_q == S_IDLE)        fcnt_q <= '0;
      else if (res_v && res_fail)   fcnt_q <= fcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      boot_q   <= 1'b1;
      pat_en_q <= '0;
      desc_q   <= 1'b0;
      rowf_q   <= 1'b0;
      pat_q    <= '0;
      pass_q   <= 1'b0;
      total_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start || boot_q) begin
          boot_q   <= 1'b0;
          pat_en_q <= cfg_pat_en;
          desc_q   <= cfg_desc;
          rowf_q   <= cfg_row_fast;
          pat_q    <= first_sel[1:0];
          state_q  <= first_sel[2] ? S_WRITE : S_FLUSH;
        end
        S_WRITE: if (last) state_q <= S_READ;
        S_READ:  if (mem_re && last) state_q <= S_DRAIN;
        S_DRAIN: if (infl_q == '0) begin
          if (next_sel[2]) begin
            pat_q   <= next_sel[1:0];
            state_q <= S_WRITE;
          end else begin
            state_q <= S_FLUSH;
          end
        end
        S_FLUSH: if (!fail_valid) begin
          pass_q  <= (fcnt_q == '0);
          total_q <= fcnt_q;
          state_q <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_no_idle_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

  p_we_re_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_drained_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!fail_valid && infl_q == '0));

  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(pat_en_q) && $stable(desc_q) && $stable(rowf_q)));
endmodule

// File: tb/mem_selftest_bench.sv
module mem_selftest_bench;
  localparam int ROW_W = 3, COL_W = 3, DATA_W = 32, RD_LAT = 2;
  localparam int AW = ROW_W + COL_W, N = 1 << AW, CW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] cfg_pat_en = 4'b1111;
  logic cfg_desc = 1'b0, cfg_row_fast = 1'b0;
  logic busy, done, pass, mem_we, mem_re, fail_valid, fail_ready;
  logic [CW-1:0] fail_total;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata, fail_mask;

  always #4 clk = ~clk;

  mem_selftest #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_mem_selftest (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_pat_en(cfg_pat_en),
    .cfg_desc(cfg_desc), .cfg_row_fast(cfg_row_fast), .busy(busy), .done(done),
    .pass(pass), .fail_total(fail_total), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .fail_valid(fail_valid), .fail_ready(fail_ready), .fail_addr(fail_addr),
    .fail_mask(fail_mask)
  );

  // memory model with stuck bits
  logic [DATA_W-1:0] mem [N];
  logic [DATA_W-1:0] s1 [N];
  logic [DATA_W-1:0] s0 [N];
  logic [DATA_W-1:0] rp [RD_LAT];
  assign mem_rdata = rp[RD_LAT-1];

  function automatic logic [DATA_W-1:0] faulty(input int a, input logic [DATA_W-1:0] v);
    return (v | s1[a]) & ~s0[a];
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    rp[0] <= faulty(int'(mem_addr), mem[mem_addr]);
    for (int s = 1; s < RD_LAT; s++) rp[s] <= rp[s-1];
  end

  int total = 0, bad = 0;
  int cyc = 0;
  int wlog [4*N];
  int rlog [4*N];
  int ri_cyc [4*N];
  int wcnt = 0, rcnt = 0, run = 0, min_run = 1 << 20, max_run = 0;
  int ga [4*N];
  logic [DATA_W-1:0] gm [4*N];
  int gn = 0;
  int fv_cyc = -1;
  int stall_err = 0;
  logic pv = 1'b0, pr = 1'b0;
  logic [AW-1:0] pa;
  logic [DATA_W-1:0] pm;
  int bp_mode = 0;
  logic [7:0] lfsr = 8'h5a;

  // monitors: values sampled at rising edges were set up on the prior falling edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) begin wlog[wcnt] <= int'(mem_addr); wcnt <= wcnt + 1; end
    if (mem_re) begin
      rlog[rcnt] <= int'(mem_addr); ri_cyc[rcnt] <= cyc; rcnt <= rcnt + 1;
      run <= run + 1;
    end else if (run != 0) begin
      if (run < min_run) min_run <= run;
      if (run > max_run) max_run <= run;
      run <= 0;
    end
    if (fail_valid && fv_cyc < 0) fv_cyc <= cyc;
    if (fail_valid && fail_ready) begin
      ga[gn] <= int'(fail_addr); gm[gn] <= fail_mask; gn <= gn + 1;
    end
    if (pv && !pr && !(fail_valid && fail_addr == pa && fail_mask == pm))
      stall_err <= stall_err + 1;
    pv <= fail_valid; pr <= fail_ready; pa <= fail_addr; pm <= fail_mask;
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    fail_ready <= (bp_mode == 0) ? 1'b1 : (lfsr[0] & lfsr[2]);
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // reference address order and pattern from the requirements
  function automatic int ref_addr(input int i, input bit d, input bit rf);
    int lin = d ? (N - 1 - i) : i;
    if (rf) return (lin % 8) * 8 + (lin / 8);
    return lin;
  endfunction

  function automatic logic [DATA_W-1:0] ref_pat(input int p, input int a);
    logic [DATA_W-1:0] c = (((a % 2) ^ ((a / 8) % 2)) != 0) ? 32'h55555555 : 32'hAAAAAAAA;
    case (p)
      0: return '0;
      1: return '1;
      2: return c;
      default: return ~c;
    endcase
  endfunction

  int ea [4*N];
  logic [DATA_W-1:0] em [4*N];
  int en = 0, first_k = -1, npat = 0;

  task automatic build_expect(input logic [3:0] m, input bit d, input bit rf);
    int k = 0;
    en = 0; first_k = -1; npat = 0;
    for (int p = 0; p < 4; p++) begin
      if (m[p]) begin
        npat++;
        for (int i = 0; i < N; i++) begin
          int a = ref_addr(i, d, rf);
          logic [DATA_W-1:0] e = ref_pat(p, a);
          logic [DATA_W-1:0] x = e ^ faulty(a, e);
          if (x != 0) begin
            if (first_k < 0) first_k = k;
            ea[en] = a; em[en] = x; en++;
          end
          k++;
        end
      end
    end
  endtask

  task automatic clear_logs();
    @(negedge clk);
    wcnt = 0; rcnt = 0; gn = 0; fv_cyc = -1; stall_err = 0;
    min_run = 1 << 20; max_run = 0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done, req, 0, 1);
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic check_orders(input logic [3:0] m, input bit d, input bit rf, input string req);
    int errs = 0;
    for (int j = 0; j < wcnt; j++) if (wlog[j] != ref_addr(j % N, d, rf)) errs++;
    for (int j = 0; j < rcnt; j++) if (rlog[j] != ref_addr(j % N, d, rf)) errs++;
    chk(wcnt == npat * N && rcnt == npat * N, req, wcnt + rcnt, 2 * npat * N);
    chk(errs == 0, req, errs, 0);
  endtask

  task automatic check_records(input string req);
    int errs = 0;
    chk(gn == en, req, gn, en);
    for (int j = 0; j < en && j < gn; j++)
      if (ga[j] != ea[j] || gm[j] != em[j]) errs++;
    chk(errs == 0, req, errs, 0);
    chk(int'(fail_total) == en, "R10 fail_total", int'(fail_total), en);
    chk(pass == (en == 0), "R10 pass", int'(pass), int'(en == 0));
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fail_valid && !mem_we && !mem_re, "R1 reset state",
        int'({busy, done, fail_valid, mem_we, mem_re}), 0);
  endtask

  task automatic t_boot_clean();
    bp_mode = 0;
    build_expect(4'b1111, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(busy, "R1 auto start", int'(busy), 1);
    wait_done("R1 boot run done");
    check_orders(4'b1111, 1'b0, 1'b0, "R4 R5 boot order");
    check_records("R6 clean");
    chk(min_run == N && max_run == N, "R9 one read per cycle", min_run, N);
    @(negedge clk);
    chk(!done && !busy, "R10 done single pulse", int'(done), 0);
  endtask

  task automatic t_faults();
    s1[5] = 32'h00000008;
    s0[18] = 32'h00000001;
    s1[40] = 32'h80000080;
    s0[63] = 32'h0000FF00;
    s1[9] = 32'h00010000; s0[9] = 32'h00000004;
    bp_mode = 0;
    cfg_pat_en = 4'b1111; cfg_desc = 1'b0; cfg_row_fast = 1'b0;
    build_expect(4'b1111, 1'b0, 1'b0);
    clear_logs();
    pulse_start();
    wait_done("R6 fault run done");
    check_records("R6 fault records");
    chk(fv_cyc - ri_cyc[first_k] == RD_LAT + 1, "R7 record latency",
        fv_cyc - ri_cyc[first_k], RD_LAT + 1);
    chk(min_run == N, "R9 no stall with ready", min_run, N);
  endtask

  task automatic t_backpressure();
    bp_mode = 1;
    cfg_pat_en = 4'b0101; cfg_desc = 1'b1; cfg_row_fast = 1'b1;
    build_expect(4'b0101, 1'b1, 1'b1);
    clear_logs();
    pulse_start();
    wait_done("R8 backpressure run done");
    check_orders(4'b0101, 1'b1, 1'b1, "R5 desc row-fast order");
    check_records("R8 records under backpressure");
    chk(stall_err == 0, "R8 stable while stalled", stall_err, 0);
    bp_mode = 0;
  endtask

  task automatic t_cfg_ignored();
    bp_mode = 0;
    cfg_pat_en = 4'b1000; cfg_desc = 1'b0; cfg_row_fast = 1'b1;
    build_expect(4'b1000, 1'b0, 1'b1);
    clear_logs();
    pulse_start();
    repeat (10) @(negedge clk);
    cfg_pat_en = 4'b1111; cfg_desc = 1'b1; cfg_row_fast = 1'b0;
    pulse_start();
    wait_done("R2 run done");
    check_orders(4'b1000, 1'b0, 1'b1, "R2 R3 config held");
    check_records("R2 R3 records of captured config");
    repeat (3) @(negedge clk);
    chk(!busy, "R2 start while busy ignored", int'(busy), 0);
  endtask

  task automatic t_empty();
    cfg_pat_en = 4'b0000;
    en = 0; npat = 0;
    clear_logs();
    pulse_start();
    wait_done("R11 empty run done");
    chk(pass && fail_total == 0, "R11 empty pass", int'(fail_total), 0);
    chk(wcnt == 0 && rcnt == 0, "R11 no memory access", wcnt + rcnt, 0);
  endtask

  initial begin
    for (int a = 0; a < N; a++) begin mem[a] = '0; s1[a] = '0; s0[a] = '0; end
    for (int s = 0; s < RD_LAT; s++) rp[s] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_boot_clean();
    t_faults();
    t_backpressure();
    t_cfg_ignored();
    t_empty();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule